// File: doc/BRIEF.md
# Serial memory command and program controller

This block sits behind the two-wire bus engine of a 4K-byte serial memory. The engine decodes START, STOP and the device-select byte. It tells this block that a command has begun, hands it each received byte and reports each byte it has sent. This block then turns those events into memory accesses.

For a write command, the first two received bytes form a 12-bit word address. The upper nibble of the first byte is discarded. Data bytes that follow are collected in a page buffer, which wraps inside its 32-byte page. The STOP that closes the command starts a self-timed program cycle, and only the buffered bytes are copied into the byte array. While that cycle runs, `busy` is high and every request is ignored.

For a read command, the block presents the byte at its address pointer. It advances the pointer across the whole array after each byte sent. A write-protect input shields the upper half of the array from writes, and a supply-low input vetoes any write during which it was seen. In both cases the data bytes are refused and nothing is programmed.

Top module: `eeprom_cmd_unit`

## Requirements
- R1: The first received byte of a write command supplies address bits 11:8 from its bits 3:0, and its bits 7:4 are ignored. The second byte supplies address bits 7:0.
- R2: Both address bytes of a write command are acknowledged: `rxAck` is 1 in the cycle `rxValid` is high.
- R3: Each accepted data byte goes to the current address, and only the low 5 address bits then increment (mod 32). A 33rd byte therefore replaces the first byte of the same page.
- R4: With `wp` high and address bit 11 set, data bytes get `rxAck` = 0 and the following STOP starts no program cycle, so the array is unchanged.
- R5: A STOP that ends a write with at least one accepted data byte raises `busy` in the next cycle for exactly PROG_CYCLES cycles. Afterwards only the buffered page bytes hold new values.
- R6: While `busy` is high, command, byte, send and STOP events are ignored and `rxAck` stays 0.
- R7: Reads return stored data regardless of `wp`.
- R8: After a write or a read, the pointer holds the address after the last one accessed. A read command starts at that pointer (current-address read).
- R9: A write command that ends after its two address bytes loads the pointer but leaves `busy` low. A following read command starts at the loaded address (random read).
- R10: During a read, each `txDone` advances the pointer by one over all 12 bits, wrapping from 0xFFF to 0x000.
- R11: If `vccLow` is high in any cycle from the write command to its STOP, data bytes from then on get `rxAck` = 0 and no program cycle starts.
- R12: After reset, `busy` is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Pulse: START plus matching device select seen |
| cmdRead | input | 1 | Direction bit of that command, 1 = read |
| rxValid | input | 1 | Pulse: a byte from the master is presented |
| rxByte | input | 8 | Received byte |
| rxAck | output | 1 | Acknowledge decision for the presented byte |
| txDone | input | 1 | Pulse: the engine finished sending `txByte` |
| txByte | output | 8 | Byte at the pointer, to be sent |
| stopEv | input | 1 | Pulse: STOP seen |
| wp | input | 1 | Write protect for the upper half |
| vccLow | input | 1 | Supply below write threshold |
| busy | output | 1 | Program cycle in progress |

## Verification
The write path is exercised with a single byte, a 34-byte burst that crosses the page wrap, and a short burst into an already programmed page. Together these separate overwrite-in-page from overflow into the next page, and show whether unbuffered bytes are left alone. Protected writes, supply-low writes (raised in the address phase, and again after a byte has been accepted) and address-only writes are each followed by reads, so refused or skipped programming shows up as old data. Read sequences cover current-address, random, protected-half and the 0xFFF-to-0x000 wrap. Commands issued during a program cycle show whether `busy` truly blocks requests.

// File: rtl/eep_cmd_pkg.sv
package eep_cmd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldHi;     // capture high address nibble
    logic ldPtr;    // load full pointer
    logic bufWr;    // write page buffer entry at pointer
    logic incPage;  // advance pointer inside page
    logic incRead;  // advance pointer across array
    logic clrBuf;   // drop buffered bytes
    logic commit;   // copy buffered bytes into array
  } eepStrb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_AHI, S_ALO, S_DATA, S_READ, S_PROG
  } eepState_t;

endpackage

// File: rtl/eep_dpath.sv
module eep_dpath
  import eep_cmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  eepStrb_t   strb,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic       ptrTop,
  output logic       anyBuf
);
  localparam int PAGE_W    = $clog2(PAGE_BYTES);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int HI_W      = ADDR_W - 8;

  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0]   hiNib;
  logic [PAGE_BYTES-1:0] pgVal;
  logic [7:0] pgBuf [PAGE_BYTES];
  logic [7:0] memArr [MEM_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      hiNib <= '0;
    end else begin
      if (strb.ldHi) hiNib <= rxByte[HI_W-1:0];
      if (strb.ldPtr)
        ptr <= {hiNib, rxByte};
      else if (strb.incPage)
        ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
      else if (strb.incRead)
        ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pgVal <= '0;
    else if (strb.clrBuf || strb.commit)
      pgVal <= '0;
    else if (strb.bufWr)
      pgVal[ptr[PAGE_W-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.bufWr) pgBuf[ptr[PAGE_W-1:0]] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pgVal[i]) memArr[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pgBuf[i];
      end
    end
  end

  assign txByte = memArr[ptr];
  assign ptrTop = ptr[ADDR_W-1];
  assign anyBuf = |pgVal;

  // R3: page advance never leaves the page
  a_r3_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPage && !strb.ldPtr |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  // R10: read advance wraps from the top to zero
  a_r10_read_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.incRead && !strb.ldPtr && !strb.incPage && (&ptr) |=> ptr == '0);

  // R5: after a commit nothing stays buffered
  a_r5_buf_drained: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !anyBuf);

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 200
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     cmdRead,
  input  logic     rxValid,
  input  logic     txDone,
  input  logic     stopEv,
  input  logic     wp,
  input  logic     vccLow,
  input  logic     ptrTop,
  input  logic     anyBuf,
  output logic     rxAck,
  output logic     busy,
  output eepStrb_t strb
);
  localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  eepState_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic lockSeen, denied;
  logic dataOk, writePhase, progGo;

  assign writePhase = (state == S_AHI) || (state == S_ALO) || (state == S_DATA);
  assign dataOk = !(denied || lockSeen || vccLow || (wp && ptrTop));
  assign progGo = (state == S_DATA) && anyBuf && !denied && !lockSeen && !vccLow;
  assign busy   = (state == S_PROG);

  always_comb begin
    nxt   = state;
    strb  = '0;
    rxAck = 1'b0;
    if (state == S_PROG) begin
      if (cnt == CNT_LAST) begin
        strb.commit = 1'b1;
        nxt = S_IDLE;
      end
    end else if (cmdStart) begin
      strb.clrBuf = 1'b1;
      nxt = cmdRead ? S_READ : S_AHI;
    end else if (stopEv) begin
      nxt = progGo ? S_PROG : S_IDLE;
    end else if (rxValid) begin
      case (state)
        S_AHI: begin
          strb.ldHi = 1'b1;
          rxAck = 1'b1;
          nxt = S_ALO;
        end
        S_ALO: begin
          strb.ldPtr = 1'b1;
          rxAck = 1'b1;
          nxt = S_DATA;
        end
        S_DATA: begin
          rxAck = dataOk;
          strb.bufWr = dataOk;
          strb.incPage = dataOk;
        end
        default: ;
      endcase
    end else if (txDone && state == S_READ) begin
      strb.incRead = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      lockSeen <= 1'b0;
      denied   <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= busy ? cnt + 1'b1 : '0;
      if (!busy && cmdStart) begin
        lockSeen <= !cmdRead && vccLow;
        denied   <= 1'b0;
      end else begin
        if (writePhase && vccLow) lockSeen <= 1'b1;
        if (state == S_DATA && rxValid && !stopEv && !dataOk) denied <= 1'b1;
      end
    end
  end

  // R2: address bytes acknowledged
  a_r2_addr_ack: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !cmdStart && !stopEv && (state == S_AHI || state == S_ALO) |-> rxAck);

  // R4: protected upper half refuses data
  a_r4_wp_nack: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && state == S_DATA && wp && ptrTop |-> !rxAck);

  // R11: supply-low refuses data
  a_r11_low_nack: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && state == S_DATA && vccLow |-> !rxAck);

  // R6: nothing moves while programming
  a_r6_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rxAck && !strb.ldHi && !strb.ldPtr && !strb.bufWr && !strb.incRead && !strb.clrBuf);

  // R5: busy only ends through a commit
  a_r5_end_commit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.commit));

  // R9: address-only write starts no program cycle
  a_r9_addr_only: assert property (@(posedge clk) disable iff (!rstN)
    stopEv && !cmdStart && state == S_DATA && !anyBuf |=> !busy);

endmodule

// File: rtl/eeprom_cmd_unit.sv
module eeprom_cmd_unit
  import eep_cmd_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdRead,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       rxAck,
  input  logic       txDone,
  output logic [7:0] txByte,
  input  logic       stopEv,
  input  logic       wp,
  input  logic       vccLow,
  output logic       busy
);
  eepStrb_t strb;
  logic ptrTop, anyBuf;

  eep_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .rxValid(rxValid), .txDone(txDone), .stopEv(stopEv), .wp(wp),
    .vccLow(vccLow), .ptrTop(ptrTop), .anyBuf(anyBuf),
    .rxAck(rxAck), .busy(busy), .strb(strb)
  );

  eep_dpath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .txByte(txByte), .ptrTop(ptrTop), .anyBuf(anyBuf)
  );

endmodule

// File: tb/eeprom_cmd_unit_tb.sv
module eeprom_cmd_unit_tb;
  localparam int CLK_P = 10;
  localparam int PROG  = 40;

  logic clk = 0, rstN = 0;
  logic cmdStart = 0, cmdRead = 0, rxValid = 0, txDone = 0, stopEv = 0;
  logic wp = 0, vccLow = 0;
  logic [7:0] rxByte = 0;
  logic rxAck, busy;
  logic [7:0] txByte;

  int nChk = 0, nFail = 0;
  string curReq = "R12";
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  eeprom_cmd_unit #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .rxValid(rxValid), .rxByte(rxByte), .rxAck(rxAck), .txDone(txDone),
    .txByte(txByte), .stopEv(stopEv), .wp(wp), .vccLow(vccLow), .busy(busy)
  );

  // behavioural reference model
  int mMode, mPtr, mHi, mProg, mBase;
  bit mLock, mDen;
  logic [7:0] mMem [4096];
  logic [7:0] pb [32];
  bit pv [32];

  function automatic bit anyPv();
    for (int i = 0; i < 32; i++) if (pv[i]) return 1;
    return 0;
  endfunction

  function automatic bit expOk();
    return !(mDen || mLock || vccLow || (wp && mPtr >= 2048));
  endfunction

  function automatic bit expAck();
    if (mProg > 0) return 0;
    if (mMode == 1 || mMode == 2) return 1;
    if (mMode == 3) return expOk();
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mPtr = 0; mHi = 0; mProg = 0; mLock = 0; mDen = 0;
      for (int i = 0; i < 32; i++) pv[i] = 0;
    end else if (mProg > 0) begin
      mProg--;
      if (mProg == 0) begin
        for (int i = 0; i < 32; i++) if (pv[i]) begin
          mMem[mBase*32 + i] = pb[i];
          pv[i] = 0;
        end
      end
    end else begin
      bit ok;
      ok = expOk();
      if (mMode >= 1 && mMode <= 3 && vccLow) mLock = 1;
      if (cmdStart) begin
        mLock = !cmdRead && vccLow;
        mDen = 0;
        for (int i = 0; i < 32; i++) pv[i] = 0;
        mMode = cmdRead ? 4 : 1;
      end else if (stopEv) begin
        if (mMode == 3 && anyPv() && !mDen && !mLock && !vccLow) begin
          mProg = PROG;
          mBase = mPtr / 32;
        end
        mMode = 0;
      end else if (rxValid) begin
        if (mMode == 1) begin
          mHi = rxByte & 8'h0F; mMode = 2;
        end else if (mMode == 2) begin
          mPtr = mHi * 256 + rxByte; mMode = 3;
        end else if (mMode == 3) begin
          if (ok) begin
            pb[mPtr % 32] = rxByte; pv[mPtr % 32] = 1;
            mPtr = (mPtr & ~31) | ((mPtr + 1) & 31);
          end else mDen = 1;
        end
      end else if (txDone && mMode == 4) begin
        mPtr = (mPtr + 1) % 4096;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("busy", int'(busy), int'(mProg > 0));
      if (rxValid) check("rxAck", int'(rxAck), int'(expAck()));
    end
  end

  // stimulus: all drives at posedge+2
  task automatic tick(); @(posedge clk); #2; endtask
  task automatic idle(int n); repeat (n) tick(); endtask
  task automatic doStart(bit rd); cmdStart = 1; cmdRead = rd; tick(); cmdStart = 0; cmdRead = 0; endtask
  task automatic doByte(logic [7:0] b); rxValid = 1; rxByte = b; tick(); rxValid = 0; endtask
  task automatic doStop(); stopEv = 1; tick(); stopEv = 0; endtask
  task automatic doTx();
    @(negedge clk);
    check("txByte", int'(txByte), int'(mMem[mPtr]));
    tick();
    txDone = 1; tick(); txDone = 0;
  endtask

  function automatic logic [7:0] dat(int seed, int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  // R1: junk in upper nibble of the first address byte
  task automatic writeRun(int addr, int n, int seed);
    doStart(0);
    doByte(8'(8'hA0 | ((addr >> 8) & 15)));
    doByte(8'(addr & 255));
    for (int i = 0; i < n; i++) doByte(dat(seed, i));
    doStop();
    idle(PROG + 3);
  endtask

  task automatic randRead(int addr, int n);
    doStart(0);
    doByte(8'(8'h50 | ((addr >> 8) & 15)));
    doByte(8'(addr & 255));
    doStart(1);
    for (int i = 0; i < n; i++) doTx();
    doStop();
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    curReq = "R12";
    check("busy after reset", int'(busy), 0);

    // R1 R2 R5: byte write, then read back
    curReq = "R1";
    writeRun(12'h123, 2, 1);
    curReq = "R9";
    randRead(12'h123, 1);
    curReq = "R8";  // current read continues at 0x124
    doStart(1); doTx(); doStop(); idle(2);

    // R12: pointer returns to 0 after reset
    curReq = "R12";
    writeRun(12'h000, 1, 9);
    rstN = 0; idle(2); rstN = 1; idle(1);
    doStart(1); doTx(); doStop(); idle(2);

    // R3: 34 bytes wrap inside page 0x040
    curReq = "R3";
    writeRun(12'h040, 34, 3);
    randRead(12'h040, 32);

    // R5: partial rewrite keeps neighbours
    curReq = "R5";
    writeRun(12'h050, 2, 5);
    randRead(12'h04E, 6);

    // R6: requests during program cycle
    curReq = "R6";
    doStart(0); doByte(8'h00); doByte(8'h40); doByte(8'h77); doStop();
    doStart(0); doByte(8'h00); doByte(8'h60); doByte(8'h99); doStop();
    doStart(1); idle(PROG + 3);
    randRead(12'h040, 2);

    // R4 R7: protection of upper half
    curReq = "R4";
    writeRun(12'h800, 2, 6);
    wp = 1;
    writeRun(12'h800, 2, 8);
    curReq = "R7";
    randRead(12'h800, 2);
    curReq = "R4";  // lower half still writable under wp
    writeRun(12'h100, 1, 11);
    randRead(12'h100, 1);
    wp = 0;

    // R11: supply low in address phase, then after one accepted byte
    curReq = "R11";
    doStart(0); vccLow = 1; doByte(8'h01); vccLow = 0; doByte(8'h23);
    doByte(8'hEE); doStop(); idle(PROG + 3);
    doStart(0); doByte(8'h08); doByte(8'h00); doByte(8'h11);
    vccLow = 1; tick(); vccLow = 0; doByte(8'h22); doStop(); idle(PROG + 3);
    randRead(12'h123, 1);
    randRead(12'h800, 2);

    // R9: address-only write leaves busy low
    curReq = "R9";
    doStart(0); doByte(8'h00); doByte(8'h45); doStop(); idle(3);
    doStart(1); doTx(); doStop(); idle(2);

    // R10: sequential read wraps across the array
    curReq = "R10";
    writeRun(12'hFFE, 2, 12);
    writeRun(12'h001, 2, 14);
    randRead(12'hFFE, 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule